// File: doc/BRIEF.md
# Three-Phase Centre-Aligned PWM Generator with Dead Band

This block drives the six gate signals of a three-leg inverter. One up/down counter sets the switching period, so the pulses are centred on the period boundary. Each leg compares the counter against its own duty value and produces a complementary high-side and low-side pair. Both sides are trimmed so that a dead band separates them. A pulse that ends up narrower than a programmable minimum is dropped for the whole period. The outputs can be masked one by one, gated by a fast chopping carrier and inverted by a polarity pin. A one-cycle sync pulse marks the start of every period and can serve as a converter start.

Software writes the half-period, the three duties, the dead time, the minimum width and a control word through a small write-only port. Period and duty writes go into staging registers. They are copied into working registers at the period start, and also at the counter turnaround when double update is selected. Two shutdown sources exist: a direct trip pin, and an auxiliary pin that must stay low for two clocks. Either one latches a flag and blanks all outputs. The outputs come back only after the flag is cleared and a new period begins.

The counter controller has three states. In S_HALT the counter is held at zero and the outputs are inactive. In S_UP the counter counts up. In S_DOWN it counts back down. The transitions are:
- start: S_HALT to S_UP, when the staged period is non-zero.
- turn: S_UP to S_DOWN, when the count reaches the period minus one.
- wrap: S_DOWN to S_UP, when the count reaches zero and the staged period is non-zero.
- stop: S_DOWN to S_HALT, when the count reaches zero and the staged period is zero.

Top module: `pwm3_gen`

## Requirements
- R1: With half-period P (P > 0), the counter runs 0..P-1 up and then P-1..0 down, so a period lasts 2P clocks. sync_o is high for exactly one clock at the first cycle of each period. With P = 0 the block halts after the current period, sends no sync and keeps every output inactive.
- R2: Per leg, let Dc = min(duty, P). In a period the high side is active for 2*(Dc-DT) clocks and the low side for 2*(P-Dc-DT) clocks, where DT is the dead time; a negative result means zero. The high and low sides of one leg are never active together.
- R3: Let w be a side's per-half width (Dc-DT for the high side, P-Dc-DT for the low side). If w is non-zero but less than the minimum width, that side stays inactive for the whole period. If w equals the minimum width, the side is not suppressed.
- R4: Period and duty writes take effect at the next period start. When control bit 6 (double update) is set, they also take effect at the turnaround, so the down half uses the new duty.
- R5: With pol_hi = 1 the outputs are active-high; with pol_hi = 0 they are active-low. Inactive outputs, including those during reset, drive the opposite level.
- R6: Bits 5:0 of the control word enable the outputs, one bit each, in the same order as gate_o: bit 0 A high, 1 A low, 2 B high, 3 B low, 4 C high, 5 C low. A cleared bit holds that output inactive.
- R7: With control bit 7 (chop) set, an output that would be active is passed only during the first two clocks of every four, counted from the period start.
- R8: trip_n low at a clock edge sets trip_flag_o. While trip_n is low, all outputs are inactive at once. After a trip the outputs stay inactive until the flag is cleared and a new period starts. A trip at the same edge as a clear wins.
- R9: aux_trip_n low at two consecutive edges sets the flag, with the same effect as R8. A single low clock is ignored.
- R10: Write map (wr_addr): 0 half-period; 1, 2 and 3 duty A, B and C; 4 dead time; 5 minimum width; 6 control word; 7 clears the trip flag when data bit 0 is 1. Dead time, minimum width and control take effect at once.
- R11: After reset all outputs are inactive, sync_o and trip_flag_o are 0, P and the duties are 0, and the control word is 0x3F (all outputs enabled, single update, no chop).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pol_hi | input | 1 | 1 = active-high outputs, 0 = active-low |
| trip_n | input | 1 | Direct shutdown, active low |
| aux_trip_n | input | 1 | Auxiliary shutdown, active low, two-clock qualified |
| gate_o | output | 6 | Gate drives {C lo, C hi, B lo, B hi, A lo, A hi} |
| sync_o | output | 1 | One-clock pulse at each period start |
| trip_flag_o | output | 1 | Latched shutdown flag |

## Verification
Two pairs of functions can land in one cycle, and the bench provokes both. First, a trip-clear write can meet a trip pin that is still low: the bench holds trip_n low on the very edge that captures the clear, and expects the flag to stay set. Second, a duty write can land in the same period as a double-update turnaround: the bench writes a new duty a few clocks into a period. It then expects the high-side count for that period to be the old width from the up half plus the new width from the down half. In single-update mode it expects the old width for both halves.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    typedef enum logic [1:0] {S_HALT, S_UP, S_DOWN} cnt_state_t;

    localparam int unsigned NPH  = 3;
    localparam int unsigned NOUT = 2 * NPH;

    localparam logic [2:0] ADR_PER   = 3'd0;
    localparam logic [2:0] ADR_DUTY0 = 3'd1;
    localparam logic [2:0] ADR_DT    = 3'd4;
    localparam logic [2:0] ADR_MP    = 3'd5;
    localparam logic [2:0] ADR_CTRL  = 3'd6;
    localparam logic [2:0] ADR_CLR   = 3'd7;

    localparam int unsigned CTL_DBL  = 6;
    localparam int unsigned CTL_CHOP = 7;
    localparam logic [7:0]  CTL_RST  = 8'h3F;
endpackage

// File: rtl/pwm3_regs.sv
module pwm3_regs
    import pwm3_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [2:0]               wr_addr,
    input  logic [CW-1:0]            wr_data,
    input  logic                     ld,
    output logic [CW-1:0]            per_stg,
    output logic [CW-1:0]            per_sh,
    output logic [NPH-1:0][CW-1:0]   duty_sh,
    output logic [CW-1:0]            dt,
    output logic [CW-1:0]            mp,
    output logic [NOUT-1:0]          mask,
    output logic                     dbl,
    output logic                     chop,
    output logic                     clr
);
    logic [NPH-1:0][CW-1:0] duty_stg;
    logic [7:0]             ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_stg  <= '0;
            duty_stg <= '0;
            dt       <= '0;
            mp       <= '0;
            ctrl_q   <= CTL_RST;
        end else if (wr_en) begin
            if (wr_addr == ADR_PER)  per_stg <= wr_data;
            if (wr_addr == ADR_DT)   dt      <= wr_data;
            if (wr_addr == ADR_MP)   mp      <= wr_data;
            if (wr_addr == ADR_CTRL) ctrl_q  <= wr_data[7:0];
            for (int i = 0; i < NPH; i++) begin
                if (wr_addr == ADR_DUTY0 + 3'(i)) duty_stg[i] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_sh  <= '0;
            duty_sh <= '0;
        end else if (ld) begin
            per_sh  <= per_stg;
            duty_sh <= duty_stg;
        end
    end

    assign mask = ctrl_q[NOUT-1:0];
    assign dbl  = ctrl_q[CTL_DBL];
    assign chop = ctrl_q[CTL_CHOP];
    assign clr  = wr_en && (wr_addr == ADR_CLR) && wr_data[0];

    // R4: working copies change only on a load strobe
    p_shadow_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> ($stable(per_sh) && $stable(duty_sh)));
endmodule

// File: rtl/pwm3_cnt.sv
module pwm3_cnt
    import pwm3_pkg::*;
#(
    parameter int CW  = 16,
    parameter int CHW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   per_stg,
    input  logic [CW-1:0]   per_sh,
    input  logic            dbl,
    output logic [CW-1:0]   cnt,
    output logic [CHW-1:0]  chop_cnt,
    output cnt_state_t      st,
    output logic            ld,
    output logic            start
);
    cnt_state_t nx;
    logic       ld_start, ld_mid;

    always_comb begin
        nx       = st;
        ld_start = 1'b0;
        ld_mid   = 1'b0;
        unique case (st)
            S_HALT: if (per_stg != '0) begin
                nx       = S_UP;
                ld_start = 1'b1;
            end
            S_UP: if (cnt == per_sh - 1'b1) begin
                nx     = S_DOWN;
                ld_mid = 1'b1;
            end
            S_DOWN: if (cnt == '0) begin
                if (per_stg == '0) begin
                    nx = S_HALT;
                end else begin
                    nx       = S_UP;
                    ld_start = 1'b1;
                end
            end
            default: nx = S_HALT;
        endcase
        ld = ld_start | (ld_mid & dbl);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_HALT;
        else        st <= nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            chop_cnt <= '0;
        end else begin
            unique case (st)
                S_HALT: cnt <= '0;
                S_UP:   if (nx == S_UP) cnt <= cnt + 1'b1;
                S_DOWN: if (cnt != '0) cnt <= cnt - 1'b1;
                default: cnt <= '0;
            endcase
            chop_cnt <= ld_start ? '0 : chop_cnt + 1'b1;
        end
    end

    assign start = (st == S_UP) && (cnt == '0);

    // R1: on the way up the count stays below the half-period
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_UP) |-> (cnt < per_sh));
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] per,
    input  logic [CW-1:0] duty,
    input  logic [CW-1:0] dt,
    input  logic [CW-1:0] mp,
    output logic          hi_on,
    output logic          lo_on
);
    logic [CW-1:0] dc, rest, hw, lw;
    logic          hi_ok, lo_ok;

    always_comb begin
        dc    = (duty > per) ? per : duty;
        rest  = per - dc;
        hw    = (dc > dt) ? dc - dt : '0;
        lw    = (rest > dt) ? rest - dt : '0;
        hi_ok = (hw != '0) && (hw >= mp);
        lo_ok = (lw != '0) && (lw >= mp);
        hi_on = hi_ok && (cnt < hw);
        lo_on = lo_ok && (cnt >= per - lw);
    end
endmodule

// File: rtl/pwm3_trip.sv
module pwm3_trip (
    input  logic clk,
    input  logic rst_n,
    input  logic trip_n,
    input  logic aux_trip_n,
    input  logic clr,
    input  logic start,
    output logic flag_q,
    output logic blank_q
);
    logic aux_d, evt;

    assign evt = !trip_n || (!aux_trip_n && !aux_d);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aux_d   <= 1'b1;
            flag_q  <= 1'b0;
            blank_q <= 1'b0;
        end else begin
            aux_d <= aux_trip_n;
            if (evt)      flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
            if (evt)                  blank_q <= 1'b1;
            else if (start && !flag_q) blank_q <= 1'b0;
        end
    end

    // R8: a trip pin sampled low always leaves the flag set
    p_trip_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !trip_n |=> flag_q);
    // R9: one low sample of the auxiliary pin cannot set the flag
    p_aux_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_d && trip_n && !flag_q) |=> !flag_q);
    // R8: while the flag is set the outputs stay blanked
    p_flag_blank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> blank_q);
endmodule

// File: rtl/pwm3_gen.sv
module pwm3_gen
    import pwm3_pkg::*;
#(
    parameter int CW       = 16,
    parameter int CHOP_BIT = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          pol_hi,
    input  logic          trip_n,
    input  logic          aux_trip_n,
    output logic [5:0]    gate_o,
    output logic          sync_o,
    output logic          trip_flag_o
);
    localparam int CHW = CHOP_BIT + 1;

    logic [CW-1:0]          per_stg, per_sh, dt, mp, cnt;
    logic [NPH-1:0][CW-1:0] duty_sh;
    logic [NOUT-1:0]        mask, act_d, act_q;
    logic [NPH-1:0]         hi_on, lo_on;
    logic [CHW-1:0]         chop_cnt;
    logic                   dbl, chop, clr, ld, start, run, carrier;
    logic                   flag_q, blank_q, sync_q;
    cnt_state_t             st;

    pwm3_regs #(.CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ld(ld), .per_stg(per_stg), .per_sh(per_sh),
        .duty_sh(duty_sh), .dt(dt), .mp(mp), .mask(mask), .dbl(dbl),
        .chop(chop), .clr(clr)
    );

    pwm3_cnt #(.CW(CW), .CHW(CHW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .per_stg(per_stg), .per_sh(per_sh),
        .dbl(dbl), .cnt(cnt), .chop_cnt(chop_cnt), .st(st), .ld(ld),
        .start(start)
    );

    pwm3_trip u_trip (
        .clk(clk), .rst_n(rst_n), .trip_n(trip_n), .aux_trip_n(aux_trip_n),
        .clr(clr), .start(start), .flag_q(flag_q), .blank_q(blank_q)
    );

    assign run     = (st != S_HALT);
    assign carrier = !chop || !chop_cnt[CHOP_BIT];

    for (genvar p = 0; p < NPH; p++) begin : g_leg
        pwm3_leg #(.CW(CW)) u_leg (
            .cnt(cnt), .per(per_sh), .duty(duty_sh[p]), .dt(dt), .mp(mp),
            .hi_on(hi_on[p]), .lo_on(lo_on[p])
        );
        assign act_d[2*p]   = run && carrier && mask[2*p]   && hi_on[p];
        assign act_d[2*p+1] = run && carrier && mask[2*p+1] && lo_on[p];

        // R2: the two sides of a leg are never driven together
        p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(act_q[2*p] && act_q[2*p+1]));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= '0;
            sync_q <= 1'b0;
        end else begin
            act_q  <= act_d;
            sync_q <= start;
        end
    end

    assign gate_o      = (act_q & {NOUT{trip_n && !blank_q}}) ^ {NOUT{!pol_hi}};
    assign sync_o      = sync_q;
    assign trip_flag_o = flag_q;

    // R1: the sync pulse lasts a single clock
    p_sync_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q |=> !sync_q);
endmodule

// File: tb/tb_pwm3_gen.sv
module tb_pwm3_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, wr_en, pol_hi, trip_n, aux_trip_n;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [5:0]  gate_o;
    logic        sync_o, trip_flag_o;

    int checks = 0;
    int errors = 0;
    int act_cnt [6];
    int len, ovl;

    // P, duty, dead time, min width, expected A high, expected A low, min-width row
    localparam int NV = 9;
    localparam int VEC [NV][7] = '{
        '{20, 10, 0, 0, 20, 20, 0},
        '{20, 10, 2, 0, 16, 16, 0},
        '{20,  5, 1, 0,  8, 28, 0},
        '{20,  0, 0, 0,  0, 40, 0},
        '{20, 25, 0, 0, 40,  0, 0},
        '{20,  4, 1, 4,  0, 30, 1},
        '{20, 17, 1, 4, 32,  0, 1},
        '{16,  8, 3, 5, 10, 10, 1},
        '{20,  5, 1, 4,  8, 28, 1}
    };

    pwm3_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pol_hi(pol_hi), .trip_n(trip_n),
        .aux_trip_n(aux_trip_n), .gate_o(gate_o), .sync_o(sync_o),
        .trip_flag_o(trip_flag_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_sync();
        do @(negedge clk); while (!sync_o);
    endtask

    // Skips to the second period start, then counts one full period.
    task automatic measure(input int wr_at, input logic [2:0] wa, input logic [15:0] wd);
        int k;
        wait_sync();
        wait_sync();
        for (int i = 0; i < 6; i++) act_cnt[i] = 0;
        ovl = 0;
        k = 0;
        do begin
            for (int i = 0; i < 6; i++) if (gate_o[i] == pol_hi) act_cnt[i]++;
            for (int p = 0; p < 3; p++)
                if (gate_o[2*p] == pol_hi && gate_o[2*p+1] == pol_hi) ovl++;
            if (k == wr_at) begin
                wr_en = 1'b1; wr_addr = wa; wr_data = wd;
            end
            @(negedge clk);
            wr_en = 1'b0;
            k++;
        end while (!sync_o);
        len = k;
    endtask

    task automatic set_all(input int p, input int d, input int t, input int m);
        wr(3'd0, 16'(p)); wr(3'd1, 16'(d)); wr(3'd2, 16'(d)); wr(3'd3, 16'(d));
        wr(3'd4, 16'(t)); wr(3'd5, 16'(m));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int nsync;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        pol_hi = 1'b1; trip_n = 1'b1; aux_trip_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 reset gates", int'(gate_o), 0);
        chk("R11 reset sync", int'(sync_o), 0);
        chk("R11 reset flag", int'(trip_flag_o), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk("R1 halted with zero period", int'(gate_o) + int'(sync_o), 0);

        // main table: R2 dead band and saturation, R3 minimum width
        for (int v = 0; v < NV; v++) begin
            set_all(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            measure(-1, 3'd0, 16'd0);
            chk("R1 period length", len, 2 * VEC[v][0]);
            chk(VEC[v][6] != 0 ? "R3 A high width" : "R2 A high width", act_cnt[0], VEC[v][4]);
            chk(VEC[v][6] != 0 ? "R3 A low width"  : "R2 A low width",  act_cnt[1], VEC[v][5]);
            chk("R2 no overlap", ovl, 0);
        end

        // R2/R10: distinct duties per leg
        set_all(20, 10, 0, 0);
        wr(3'd2, 16'd4); wr(3'd3, 16'd16);
        measure(-1, 3'd0, 16'd0);
        chk("R10 B high width", act_cnt[2], 8);
        chk("R10 B low width", act_cnt[3], 32);
        chk("R10 C high width", act_cnt[4], 32);
        chk("R10 C low width", act_cnt[5], 8);

        // R4: single update keeps the old duty for the whole period
        set_all(20, 10, 0, 0);
        measure(3, 3'd1, 16'd4);
        chk("R4 single update same period", act_cnt[0], 20);
        measure(-1, 3'd0, 16'd0);
        chk("R4 single update next period", act_cnt[0], 8);
        // R4: double update applies the new duty in the down half
        wr(3'd1, 16'd10);
        wr(3'd6, 16'h007F);
        measure(3, 3'd1, 16'd4);
        chk("R4 double update split period", act_cnt[0], 14);
        wr(3'd6, 16'h003F);

        // R6: mask A high only
        set_all(20, 10, 0, 0);
        wr(3'd6, 16'h003E);
        measure(-1, 3'd0, 16'd0);
        chk("R6 masked A high", act_cnt[0], 0);
        chk("R6 A low still on", act_cnt[1], 20);
        chk("R6 B high still on", act_cnt[2], 20);

        // R7: chopping carrier
        wr(3'd6, 16'h00BF);
        measure(-1, 3'd0, 16'd0);
        chk("R7 chopped A high", act_cnt[0], 10);
        chk("R7 chopped A low", act_cnt[1], 10);
        wr(3'd6, 16'h003F);

        // R5: active-low outputs
        pol_hi = 1'b0;
        measure(-1, 3'd0, 16'd0);
        chk("R5 active-low A high", act_cnt[0], 20);
        chk("R5 active-low A low", act_cnt[1], 20);
        pol_hi = 1'b1;

        // R8: trip kills outputs at once and latches
        wait_sync();
        repeat (4) @(negedge clk);
        chk("R8 A high before trip", int'(gate_o[0]), 1);
        trip_n = 1'b0;
        #1;
        chk("R8 immediate blank", int'(gate_o), 0);
        @(negedge clk);
        trip_n = 1'b1;
        #1;
        chk("R8 flag set", int'(trip_flag_o), 1);
        chk("R8 still blank after release", int'(gate_o), 0);
        measure(-1, 3'd0, 16'd0);
        chk("R8 blank period", act_cnt[0] + act_cnt[1] + act_cnt[2] + act_cnt[3] + act_cnt[4] + act_cnt[5], 0);
        // clear and trip on the same edge: trip wins
        trip_n = 1'b0;
        wr(3'd7, 16'd1);
        trip_n = 1'b1;
        @(negedge clk);
        chk("R8 trip beats clear", int'(trip_flag_o), 1);
        wr(3'd7, 16'd1);
        chk("R8 flag cleared", int'(trip_flag_o), 0);
        measure(-1, 3'd0, 16'd0);
        chk("R8 recovery A high", act_cnt[0], 20);
        chk("R8 recovery A low", act_cnt[1], 20);

        // R9: auxiliary shutdown qualification
        aux_trip_n = 1'b0;
        @(negedge clk);
        aux_trip_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 single low ignored", int'(trip_flag_o), 0);
        measure(-1, 3'd0, 16'd0);
        chk("R9 outputs unaffected", act_cnt[0], 20);
        aux_trip_n = 1'b0;
        repeat (2) @(negedge clk);
        aux_trip_n = 1'b1;
        #1;
        chk("R9 two lows trip", int'(trip_flag_o), 1);
        chk("R9 outputs blank", int'(gate_o), 0);
        wr(3'd7, 16'd1);

        // R1: zero period halts
        wr(3'd0, 16'd0);
        repeat (60) @(negedge clk);
        nsync = 0;
        for (int i = 0; i < 60; i++) begin
            if (sync_o) nsync++;
            if (gate_o != 6'd0) nsync++;
            @(negedge clk);
        end
        chk("R1 halt no sync or gates", nsync, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule